// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the control and status register bank of a host bridge. It holds 28 words of 32 bits behind a single memory-mapped port, with one address, one write-data bus, a write strobe and a combinational read-data bus. The words carry the bridge, memory, GPIO and interrupt configuration. Each word loads a fixed value on synchronous reset. The logic that consumes these values lives elsewhere.

Most words are plain storage. The interrupt-enable word cannot be written directly. Software changes it by writing a mask to a companion set word, which ORs the mask into the enable word, or to a companion clear word, which removes the masked bits. The enable word and the interrupt-status word next to it are read-only. One bit of the general configuration word is a software reset trigger. When a write moves that bit from 0 to 1, the block emits a one-cycle system reset request.

Top module: `hbc_regfile`

## Requirements
- R1: The window spans byte offsets 0x100 to 0x16F. Word k (0 to 27) sits at offset 0x100 + 4*k. Address bits [1:0] are ignored for both reads and writes.
- R2: After reset, these words read back their defaults: 0x100 = 0x00000C40, 0x104 = 0x00001384, 0x108 = 0x2BFF8010, 0x10C = 0x255E0091, 0x110 = 0x00006140, 0x11C = 0x000001FF, 0x120 = 0x000001FF, 0x168 = 0x00000008, 0x16C = 0x10000000.
- R3: Every other word in the window reads zero after reset.
- R4: A write to any word other than 0x138 and 0x13C stores the full 32-bit value. A later read of that word returns that value.
- R5: A write of mask M to 0x130 stores M at 0x130 and sets the bits of M in the enable word at 0x138. All other enable bits keep their values.
- R6: A write of mask M to 0x134 stores M at 0x134 and clears the bits of M in the enable word at 0x138. All other enable bits keep their values.
- R7: Writes to 0x138 and 0x13C change nothing. The status word at 0x13C always reads zero.
- R8: A write to 0x104 with data bit 2 = 1, made while the stored bit 2 is 0, drives rst_req high for exactly the one cycle after the write edge. The written value is stored.
- R9: A write to 0x104 does not raise rst_req if the stored bit 2 is already 1 or if the written bit 2 is 0. No other write or read raises rst_req.
- R10: Writes outside the window change no word. Reads outside the window return zero.
- R11: rd_data follows addr in the same cycle. A write is visible to a read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset of the access |
| wr_en | input | 1 | Write strobe, acts at the rising clock edge |
| wr_data | input | 32 | Data to write |
| rd_data | output | 32 | Combinational read data for addr |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The enable word is driven with set and clear masks that overlap already-set bits, overlap already-clear bits, and use disjoint bit groups. This separates a true OR/AND-NOT update from a plain overwrite or an XOR. The reset trigger is exercised with a rising write, a repeated write while the bit is already high, and writes of 0, so that pulse logic based on level is told apart from logic based on edge. Random traffic mixes addresses inside the window, addresses just outside it and addresses with nonzero low bits. After this traffic, a full sweep compares every word with a bench model to expose stray writes or decode aliasing.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_WORDS = 28;
    localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

    // word indices with special behaviour
    localparam int unsigned IX_GENCFG = 1;
    localparam int unsigned IX_ENSET  = 12;
    localparam int unsigned IX_ENCLR  = 13;
    localparam int unsigned IX_ENABLE = 14;
    localparam int unsigned IX_STATUS = 15;
    localparam int unsigned TRIG_BIT  = 2;

    typedef enum logic [2:0] {
        K_NONE,
        K_PLAIN,
        K_GENCFG,
        K_ENSET,
        K_ENCLR,
        K_LOCKED
    } wkind_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        wkind_e           kind;
    } dec_t;

    function automatic logic [WORD_W-1:0] reset_value(int unsigned idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction

    function automatic wkind_e kind_of(int unsigned idx);
        if (idx == IX_GENCFG)                        return K_GENCFG;
        else if (idx == IX_ENSET)                    return K_ENSET;
        else if (idx == IX_ENCLR)                    return K_ENCLR;
        else if (idx == IX_ENABLE || idx == IX_STATUS) return K_LOCKED;
        else                                         return K_PLAIN;
    endfunction

endpackage

// File: rtl/hbc_addr_dec.sv
module hbc_addr_dec
    import hbc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned BASE_OFF = 32'h100
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_OFF);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_OFF + 4 * NUM_WORDS);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off      = addr - LO;
        dec.hit  = (addr >= LO) && (addr < HI);
        dec.idx  = off[IDX_W+1:2];
        dec.kind = dec.hit ? kind_of(32'(off[IDX_W+1:2])) : K_NONE;
    end
endmodule

// File: rtl/hbc_reg_bank.sv
module hbc_reg_bank
    import hbc_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  dec_t                             dec,
    input  logic [WORD_W-1:0]                wr_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        if (i == IX_ENABLE) begin : g_enable
            logic [WORD_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= reset_value(i);
                end else if (wr_en && dec.hit) begin
                    if (dec.kind == K_ENSET)
                        q <= q | wr_data;
                    else if (dec.kind == K_ENCLR)
                        q <= q & ~wr_data;
                end
            end
            assign words[i] = q;
        end else if (i == IX_STATUS) begin : g_status
            assign words[i] = reset_value(i);
        end else begin : g_plain
            logic [WORD_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reset_value(i);
                else if (wr_en && dec.hit && dec.idx == MY_IDX)
                    q <= wr_data;
            end
            assign words[i] = q;
        end
    end
endmodule

// File: rtl/hbc_rst_edge.sv
module hbc_rst_edge (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic old_bit,
    input  logic new_bit,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst)
            pulse <= 1'b0;
        else
            pulse <= fire && !old_bit && new_bit;
    end
endmodule

// File: rtl/hbc_regfile.sv
module hbc_regfile
    import hbc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned BASE_OFF = 32'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              rst_req
);
    dec_t                             dec;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic                             trig_fire;

    hbc_addr_dec #(.ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    hbc_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .dec     (dec),
        .wr_data (wr_data),
        .words   (words)
    );

    assign trig_fire = wr_en && dec.hit && (dec.kind == K_GENCFG);

    hbc_rst_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .fire    (trig_fire),
        .old_bit (words[IX_GENCFG][TRIG_BIT]),
        .new_bit (wr_data[TRIG_BIT]),
        .pulse   (rst_req)
    );

    assign rd_data = dec.hit ? words[dec.idx] : '0;
endmodule

// File: rtl/hbc_regfile_chk.sv
module hbc_regfile_chk #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned BASE_OFF = 32'h100
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic              rst_req
);
    localparam logic [31:0] GEN_B  = BASE_OFF + 4 * hbc_pkg::IX_GENCFG;
    localparam logic [31:0] SET_B  = BASE_OFF + 4 * hbc_pkg::IX_ENSET;
    localparam logic [31:0] CLR_B  = BASE_OFF + 4 * hbc_pkg::IX_ENCLR;
    localparam logic [31:0] EN_B   = BASE_OFF + 4 * hbc_pkg::IX_ENABLE;
    localparam logic [31:0] ST_B   = BASE_OFF + 4 * hbc_pkg::IX_STATUS;
    localparam logic [31:0] LO_B   = BASE_OFF;
    localparam logic [31:0] HI_B   = BASE_OFF + 4 * hbc_pkg::NUM_WORDS;

    // R8
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R9
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(!rst && wr_en && addr[ADDR_W-1:2] == GEN_B[ADDR_W-1:2] && wr_data[2]));

    // R5
    enset_or_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr_en && addr[ADDR_W-1:2] == SET_B[ADDR_W-1:2]) && addr[ADDR_W-1:2] == EN_B[ADDR_W-1:2])
        |-> ((rd_data & $past(wr_data)) == $past(wr_data)));

    // R6
    enclr_and_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr_en && addr[ADDR_W-1:2] == CLR_B[ADDR_W-1:2]) && addr[ADDR_W-1:2] == EN_B[ADDR_W-1:2])
        |-> ((rd_data & $past(wr_data)) == 32'h0));

    // R7
    status_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1:2] == ST_B[ADDR_W-1:2]) |-> (rd_data == 32'h0));

    // R10
    outside_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr < LO_B[ADDR_W-1:0] || addr >= HI_B[ADDR_W-1:0]) |-> (rd_data == 32'h0));

    // R2
    default_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && addr[ADDR_W-1:2] == LO_B[ADDR_W-1:2]) |-> (rd_data == 32'h0000_0C40));
endmodule

bind hbc_regfile hbc_regfile_chk #(.ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .rst_req (rst_req)
);

// File: tb/hbc_regfile_bench.sv
`timescale 1ns/1ps
module hbc_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rst_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [31:0] exp_w [28];

    always #5 clk = ~clk;

    hbc_regfile u_hbc_regfile (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req)
    );

    function automatic logic [31:0] dflt(int k);
        case (k)
            0: return 32'hC40;       1: return 32'h1384;
            2: return 32'h2BFF8010;  3: return 32'h255E0091;
            4: return 32'h6140;      7: return 32'h1FF;
            8: return 32'h1FF;       26: return 32'h8;
            27: return 32'h10000000; default: return 32'h0;
        endcase
    endfunction

    function automatic bit in_win(logic [11:0] a);
        return a >= 12'h100 && a < 12'h170;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // model update; returns expected pulse
    function automatic bit model_wr(logic [11:0] a, logic [31:0] d);
        int k;
        bit p = 1'b0;
        if (!in_win(a)) return 1'b0;
        k = int'((a - 12'h100) >> 2);
        if (k == 14 || k == 15) return 1'b0;
        if (k == 1) p = !exp_w[1][2] && d[2];
        exp_w[k] = d;
        if (k == 12) exp_w[14] = exp_w[14] | d;
        if (k == 13) exp_w[14] = exp_w[14] & ~d;
        return p;
    endfunction

    function automatic logic [31:0] model_rd(logic [11:0] a);
        if (!in_win(a)) return 32'h0;
        return exp_w[int'((a - 12'h100) >> 2)];
    endfunction

    task automatic wr(string req, logic [11:0] a, logic [31:0] d);
        bit p;
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        p = model_wr(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk({req, " rst_req after write"}, {31'h0, rst_req}, {31'h0, p});
    endtask

    task automatic rd(string req, logic [11:0] a);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1;
        chk(req, rd_data, model_rd(a));
        chk("R9 idle rst_req", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic sweep(string req);
        for (int k = 0; k < 28; k++) rd(req, 12'(12'h100 + 4 * k));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE1));
        for (int k = 0; k < 28; k++) exp_w[k] = dflt(k);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2 R3: reset values of every word
        sweep("R2/R3 reset value");
        // R10: outside reads
        rd("R10 read below window", 12'h0FC);
        rd("R10 read above window", 12'h170);
        rd("R10 read far", 12'hFFC);

        // R4 R11 R1: plain storage, low bits ignored
        wr("R4", 12'h140, 32'hA5A5_5A5A);
        rd("R11 readback next cycle", 12'h140);
        rd("R1 low bits ignored", 12'h143);
        wr("R1 write with low bits", 12'h14E, 32'h1234_5678);
        rd("R1 word 0x14C", 12'h14C);

        // R5 R6 enable updates
        wr("R5", 12'h130, 32'h0000_00F3);
        rd("R5 set word stores", 12'h130);
        rd("R5 enable", 12'h138);
        wr("R5", 12'h130, 32'h0000_0103);
        rd("R5 enable OR", 12'h138);
        wr("R6", 12'h134, 32'h0000_0013);
        rd("R6 clr word stores", 12'h134);
        rd("R6 enable clear", 12'h138);
        wr("R6", 12'h134, 32'h0000_0C00);
        rd("R6 clear of zero bits", 12'h138);

        // R7 read-only words
        wr("R7", 12'h138, 32'hFFFF_FFFF);
        rd("R7 enable unchanged", 12'h138);
        wr("R7", 12'h13C, 32'hFFFF_FFFF);
        rd("R7 status zero", 12'h13C);

        // R8 R9 reset trigger
        wr("R9 bit already one", 12'h104, 32'h0000_0004);
        wr("R9 write zero", 12'h104, 32'h0000_0000);
        rd("R8 value stored", 12'h104);
        wr("R8 rising", 12'h104, 32'h0000_0004);
        @(negedge clk); #1;
        chk("R8 single cycle", {31'h0, rst_req}, 32'h0);
        rd("R8 value stored", 12'h104);
        wr("R9 repeat high", 12'h104, 32'h0000_0007);
        wr("R9 other word bit2", 12'h100, 32'h0000_0004);

        // R10 outside writes
        wr("R10", 12'h170, 32'hDEAD_BEEF);
        wr("R10", 12'h0FC, 32'hDEAD_BEEF);
        rd("R10 read outside", 12'h170);
        sweep("R10 no stray write");

        // random traffic
        for (int n = 0; n < 500; n++) begin
            int r;
            logic [11:0] a;
            r = int'($urandom % 40);
            if (r < 32)      a = 12'(12'h100 + 4 * (r % 28) + int'($urandom % 4));
            else if (r < 36) a = 12'(12'h170 + 4 * int'($urandom % 8));
            else             a = 12'(12'h0C0 + 4 * int'($urandom % 16));
            if ($urandom % 2 == 0) wr("R4 random", a, $urandom);
            else                   rd("R11 random", a);
        end
        sweep("R4 final sweep");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule